// File: doc/BRIEF.md
# Flash Configuration Image Loader

This block copies a configuration image out of a parallel flash device into a target FPGA. It drives the flash bus only while an external arbiter grants it access. At the start of each attempt it latches a page number that selects one of several images stored in the flash. It then holds the target's active-low configuration-request line low for a fixed number of clocks and waits for the target's status line to come up. After that it moves one flash word per clock to the target's data port until the target reports completion on its done line.

The flash read port and the target data port carry no handshake: a word is read and delivered in any cycle where the read strobe is high. The block ends an attempt in a done or error state and stays there. A falling edge on an active-low reconfiguration input starts a new attempt, from any state. That input may come from a bounce-free switch or from other logic, and it is synchronised to the clock before it is used.

Top module: `flash_cfg_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `cfg_req_n_o` high, `flash_rd_o` low, `done_o` low and `err_o` low. No attempt begins while reset is held, whatever the grant is.
- R2: While `grant_i` is low, `flash_rd_o` is low in that same cycle and `flash_addr_o` is zero. Grant loss during an attempt returns the block to idle without a request pulse. With the grant high, an idle block starts a new attempt on the next clock.
- R3: The page field of `flash_addr_o` is the value of `page_sel_i` in the cycle the attempt started. Changes to `page_sel_i` after that point do not alter the addresses of the running attempt.
- R4: Each attempt that is not cut short drives `cfg_req_n_o` low for exactly REQ_CYCLES consecutive cycles.
- R5: `flash_addr_o` equals page × 2^⌈log2 IMG_WORDS⌉ plus a word index. The word index is 0 for the first read of an attempt and grows by one for each cycle in which `flash_rd_o` is high. `tgt_data_o` equals `flash_data_i` and `tgt_valid_o` equals `flash_rd_o`.
- R6: No read occurs before `tgt_status_i` has been seen high after the request pulse. If `tgt_status_i` is low while streaming, `flash_rd_o` drops in that same cycle and `err_o` is high from the next cycle.
- R7: If `tgt_done_i` is high while streaming, `flash_rd_o` drops in that same cycle and `done_o` is high from the next cycle. The number of words delivered equals the number sent before done was raised.
- R8: If `tgt_status_i` stays low after the request pulse, exactly STATUS_TIMEOUT waiting cycles pass and then `err_o` goes high, with no reads.
- R9: If IMG_WORDS words have been delivered and done has not risen, reading stops and `err_o` goes high.
- R10: A falling edge on `reconf_n_i`, after a two-flop synchroniser, restarts the sequence from any state with a fresh request pulse and word index 0. A level held low causes only one restart.
- R11: Once `done_o` or `err_o` is high, it stays high, with no request pulse, until a restart or reset. A rising edge on `reconf_n_i` has no effect.
- R12: `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant_i | input | 1 | Flash access grant from the external arbiter |
| page_sel_i | input | PAGE_W | Image page to load, latched at attempt start |
| reconf_n_i | input | 1 | Active-low reconfiguration request, asynchronous |
| flash_addr_o | output | PAGE_W+⌈log2 IMG_WORDS⌉ | Flash word address, zero when not reading |
| flash_rd_o | output | 1 | Flash read strobe |
| flash_data_i | input | DATA_W | Flash read data, valid in the read cycle |
| cfg_req_n_o | output | 1 | Active-low configuration request to the target |
| tgt_status_i | input | 1 | Target status, high when ready and error-free |
| tgt_done_i | input | 1 | Target done, high once configured |
| tgt_data_o | output | DATA_W | Configuration word to the target |
| tgt_valid_o | output | 1 | Qualifies `tgt_data_o` |
| done_o | output | 1 | Attempt finished successfully |
| err_o | output | 1 | Attempt ended in error |

## Verification
The bench builds the block with PAGE_W=2, IMG_WORDS=6, REQ_CYCLES=4, STATUS_TIMEOUT=6 and DATA_W=8. An image length that is not a power of two leaves unused codes in the 3-bit word field, so the length limit cannot come from the counter wrapping. The small sizes let the bench run every page against every stop position: done after word k, and status loss after word k, for k from 1 to 6. It also runs the length overrun on every page, and the status timeout, where the waiting cycles are counted exactly. Grant loss, a page change mid-stream, a restart mid-stream and a held-low reconfiguration input are each driven once.

// File: rtl/ldr_pkg.sv
// Shared types for the flash configuration loader.
package ldr_pkg;
    // Sequencer states; DONE and ERROR are terminal until a restart.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_WAIT_STATUS,
        ST_STREAM,
        ST_DONE,
        ST_ERROR
    } ldr_state_e;
endpackage

// File: rtl/ldr_reconf_sync.sv
// Synchronises the asynchronous active-low reconfiguration input and
// emits a one-cycle pulse on each synchronised falling edge.
// Assumes STAGES >= 2. A level held low produces a single pulse.
module ldr_reconf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_i,
    output logic restart_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the input through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], req_n_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // A high-to-low step of the synchronised level is a restart request.
    assign restart_o = last_q && !chain_q[STAGES-1];
endmodule

// File: rtl/ldr_seq_ctrl.sv
// State sequencer of the loader: request pulse, status wait with timeout,
// streaming, and the terminal done/error states. One shared cycle counter
// times both the request pulse and the status wait.
// Assumes REQ_CYCLES >= 1 and STATUS_TIMEOUT >= 1.
module ldr_seq_ctrl
    import ldr_pkg::*;
#(
    parameter int REQ_CYCLES     = 8,
    parameter int STATUS_TIMEOUT = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grant_i,
    input  logic       restart_i,
    input  logic       status_i,
    input  logic       done_i,
    input  logic       image_end_i,
    output ldr_state_e state_o,
    output logic       start_o
);
    localparam int CNT_MAX = (REQ_CYCLES > STATUS_TIMEOUT) ? REQ_CYCLES : STATUS_TIMEOUT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] REQ_LAST = CNT_W'(REQ_CYCLES - 1);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(STATUS_TIMEOUT - 1);

    ldr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and counter decision; a restart overrides every state.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (restart_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (grant_i) begin
                        state_d = ST_REQUEST;
                        cnt_d   = '0;
                    end
                end
                ST_REQUEST: begin
                    if (!grant_i) begin
                        state_d = ST_IDLE;
                    end else if (cnt_q == REQ_LAST) begin
                        state_d = ST_WAIT_STATUS;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_WAIT_STATUS: begin
                    if (!grant_i) begin
                        state_d = ST_IDLE;
                    end else if (status_i) begin
                        state_d = ST_STREAM;
                    end else if (cnt_q == TO_LAST) begin
                        state_d = ST_ERROR;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_STREAM: begin
                    if (!grant_i) begin
                        state_d = ST_IDLE;
                    end else if (!status_i) begin
                        state_d = ST_ERROR;
                    end else if (done_i) begin
                        state_d = ST_DONE;
                    end else if (image_end_i) begin
                        state_d = ST_ERROR;
                    end
                end
                default: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;
    // An attempt begins when an idle sequencer holds the grant.
    assign start_o = (state_q == ST_IDLE) && grant_i && !restart_i;
endmodule

// File: rtl/ldr_addr_gen.sv
// Flash address generator: latches the page at attempt start and counts
// delivered words. The counter is one bit wider than the word field so
// that the image-length limit is reached without wrapping.
// Assumes IMG_WORDS >= 2.
module ldr_addr_gen #(
    parameter int PAGE_W    = 2,
    parameter int IMG_WORDS = 1024,
    parameter int WORD_AW   = $clog2(IMG_WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [PAGE_W-1:0]         page_i,
    input  logic                      step_i,
    output logic [PAGE_W+WORD_AW-1:0] addr_o,
    output logic                      image_end_o
);
    localparam logic [WORD_AW:0] LAST_COUNT = (WORD_AW + 1)'(IMG_WORDS);

    logic [PAGE_W-1:0] page_q;
    logic [WORD_AW:0]  word_q;

    // Page capture on start, word count on each delivered word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            word_q <= '0;
        end else if (start_i) begin
            page_q <= page_i;
            word_q <= '0;
        end else if (step_i) begin
            word_q <= word_q + (WORD_AW + 1)'(1);
        end
    end

    assign addr_o      = {page_q, word_q[WORD_AW-1:0]};
    assign image_end_o = (word_q == LAST_COUNT);
endmodule

// File: rtl/flash_cfg_loader.sv
// Top of the flash configuration loader. It wires the reconfiguration
// synchroniser, the state sequencer and the address generator, and it
// gates the flash read strobe combinationally with grant, status and
// done so that reading stops in the cycle those inputs change.
// Assumes all inputs except reconf_n_i are synchronous to clk.
module flash_cfg_loader
    import ldr_pkg::*;
#(
    parameter int PAGE_W         = 2,
    parameter int IMG_WORDS      = 1024,
    parameter int DATA_W         = 16,
    parameter int REQ_CYCLES     = 8,
    parameter int STATUS_TIMEOUT = 1000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  grant_i,
    input  logic [PAGE_W-1:0]                     page_sel_i,
    input  logic                                  reconf_n_i,
    output logic [PAGE_W+$clog2(IMG_WORDS)-1:0]   flash_addr_o,
    output logic                                  flash_rd_o,
    input  logic [DATA_W-1:0]                     flash_data_i,
    output logic                                  cfg_req_n_o,
    input  logic                                  tgt_status_i,
    input  logic                                  tgt_done_i,
    output logic [DATA_W-1:0]                     tgt_data_o,
    output logic                                  tgt_valid_o,
    output logic                                  done_o,
    output logic                                  err_o
);
    localparam int WORD_AW = $clog2(IMG_WORDS);
    localparam int ADDR_W  = PAGE_W + WORD_AW;

    ldr_state_e        state;
    logic              restart;
    logic              start;
    logic              image_end;
    logic              rd;
    logic [ADDR_W-1:0] addr;

    ldr_reconf_sync #(
        .STAGES(2)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_n_i  (reconf_n_i),
        .restart_o(restart)
    );

    ldr_seq_ctrl #(
        .REQ_CYCLES    (REQ_CYCLES),
        .STATUS_TIMEOUT(STATUS_TIMEOUT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_i    (grant_i),
        .restart_i  (restart),
        .status_i   (tgt_status_i),
        .done_i     (tgt_done_i),
        .image_end_i(image_end),
        .state_o    (state),
        .start_o    (start)
    );

    ldr_addr_gen #(
        .PAGE_W   (PAGE_W),
        .IMG_WORDS(IMG_WORDS),
        .WORD_AW  (WORD_AW)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .page_i     (page_sel_i),
        .step_i     (rd),
        .addr_o     (addr),
        .image_end_o(image_end)
    );

    // Read only while streaming with grant, healthy status, no done, words left.
    always_comb begin
        rd = (state == ST_STREAM) && grant_i && tgt_status_i && !tgt_done_i && !image_end;
    end

    // Bus outputs are released to zero whenever no read is in progress.
    always_comb begin
        flash_rd_o   = rd;
        flash_addr_o = rd ? addr : '0;
        tgt_valid_o  = rd;
        tgt_data_o   = rd ? flash_data_i : '0;
    end

    assign cfg_req_n_o = (state != ST_REQUEST);
    assign done_o      = (state == ST_DONE);
    assign err_o       = (state == ST_ERROR);
endmodule

// File: rtl/flash_cfg_loader_chk.sv
// Property checker for the flash configuration loader, bound to the top.
module flash_cfg_loader_chk
    import ldr_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int REQ_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant_i,
    input logic              reconf_pulse,
    input ldr_state_e        state,
    input logic [ADDR_W-1:0] flash_addr_o,
    input logic              flash_rd_o,
    input logic              cfg_req_n_o,
    input logic              tgt_status_i,
    input logic              tgt_done_i,
    input logic              done_o,
    input logic              err_o
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (cfg_req_n_o && !flash_rd_o && !done_o && !err_o)); // R1

    AST_NO_READ_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_i |-> !flash_rd_o); // R2

    AST_READ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd_o |-> tgt_status_i); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_rd_o && $past(flash_rd_o)) |-> (flash_addr_o == $past(flash_addr_o) + ADDR_W'(1))); // R5

    AST_STATUS_LOSS_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && grant_i && !reconf_pulse && !tgt_status_i) |=> err_o); // R6

    AST_DONE_ENDS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && grant_i && !reconf_pulse && tgt_status_i && tgt_done_i) |=> done_o); // R7

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !reconf_pulse) |=> (done_o && cfg_req_n_o)); // R11

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !reconf_pulse) |=> (err_o && cfg_req_n_o)); // R11

    AST_DONE_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R12

    generate
        if (REQ_CYCLES > 1) begin : g_req_width
            AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(cfg_req_n_o) && grant_i && !reconf_pulse) |=> !cfg_req_n_o); // R4
        end
    endgenerate
endmodule

bind flash_cfg_loader flash_cfg_loader_chk #(
    .ADDR_W    (PAGE_W + $clog2(IMG_WORDS)),
    .REQ_CYCLES(REQ_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_i     (grant_i),
    .reconf_pulse(restart),
    .state       (state),
    .flash_addr_o(flash_addr_o),
    .flash_rd_o  (flash_rd_o),
    .cfg_req_n_o (cfg_req_n_o),
    .tgt_status_i(tgt_status_i),
    .tgt_done_i  (tgt_done_i),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/flash_cfg_loader_test.sv
// Self-checking bench: sweeps pages and stop positions on a small build.
module flash_cfg_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int PG_W = 2;
    localparam int IMG  = 6;
    localparam int WAW  = $clog2(IMG);
    localparam int DW   = 8;
    localparam int REQ  = 4;
    localparam int TO   = 6;
    localparam int AW   = PG_W + WAW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          grant;
    logic [PG_W-1:0] page_sel;
    logic          reconf_n;
    logic [AW-1:0] flash_addr;
    logic          flash_rd;
    logic [DW-1:0] flash_data;
    logic          req_n;
    logic          tstatus;
    logic          tdone;
    logic [DW-1:0] tdata;
    logic          tvalid;
    logic          done_o;
    logic          err_o;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Flash contents: an arithmetic pattern of the address.
    function automatic logic [DW-1:0] fdat(input int a);
        return DW'(a * 37 + 11);
    endfunction
    assign flash_data = fdat(int'(flash_addr));

    flash_cfg_loader #(
        .PAGE_W(PG_W), .IMG_WORDS(IMG), .DATA_W(DW),
        .REQ_CYCLES(REQ), .STATUS_TIMEOUT(TO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .grant_i(grant), .page_sel_i(page_sel),
        .reconf_n_i(reconf_n), .flash_addr_o(flash_addr), .flash_rd_o(flash_rd),
        .flash_data_i(flash_data), .cfg_req_n_o(req_n), .tgt_status_i(tstatus),
        .tgt_done_i(tdone), .tgt_data_o(tdata), .tgt_valid_o(tvalid),
        .done_o(done_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    // Falling edge on the reconfiguration input, held low two cycles.
    task automatic kick(input int pg);
        page_sel = PG_W'(pg);
        reconf_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 reconf_n = 1'b1;
    endtask

    // One full attempt with a target model; sdel=0 means status never rises.
    task automatic attempt(input int pg, input int sdel, input int dafter, input int fafter,
                           input int exp_words, input bit exp_done, input bit exp_to,
                           input string tag);
        int req_low = 0, words = 0, waitc = 0, bad = 0, early = 0, cyc = 0;
        bit seen_req = 0, nst = 0, ndn = 0, hung = 0;
        tstatus = 1'b0;
        tdone   = 1'b0;
        kick(pg);
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 300) begin hung = 1; break; end
            if (seen_req && req_n && (done_o || err_o)) break;
            nst = tstatus;
            ndn = tdone;
            if (!req_n) begin
                seen_req = 1; req_low++; words = 0; waitc = 0; nst = 0; ndn = 0;
            end else if (seen_req) begin
                if (flash_rd) begin
                    if (!tstatus) early++;
                    if (int'(flash_addr) != pg * (1 << WAW) + words) bad++;
                    if (tdata != fdat(pg * (1 << WAW) + words) || !tvalid) bad++;
                    words++;
                    if (words == dafter) ndn = 1;
                    if (words == fafter) nst = 0;
                end else if (!tstatus && !err_o) begin
                    waitc++;
                    if (waitc == sdel) nst = 1;
                end
            end
            @(posedge clk);
            #1;
            tstatus = nst;
            tdone   = ndn;
        end
        check(!hung, tag, "attempt ended", int'(hung), 0);
        check(req_low == REQ, "R4", "request low cycles", req_low, REQ);
        check(bad == 0, "R5", "address/data mismatches", bad, 0);
        check(early == 0, "R6", "reads before status", early, 0);
        check(words == exp_words, tag, "words delivered", words, exp_words);
        check(done_o == exp_done && err_o == !exp_done, tag, "done flag",
              int'(done_o), int'(exp_done));
        check(!(done_o && err_o), "R12", "done and error together", 1, 0);
        if (exp_to) check(waitc == TO, "R8", "status wait cycles", waitc, TO);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int falls, cnt, quiet;
        bit prev;
        rst_n = 1'b0; grant = 1'b1; page_sel = '0; reconf_n = 1'b1;
        tstatus = 1'b0; tdone = 1'b0;

        // R1: reset holds the block idle even with grant high.
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(req_n && !flash_rd && !done_o && !err_o && flash_addr == '0, "R1",
              "idle outputs in reset", int'(req_n), 1);

        // R2: no attempt while grant is low.
        #1 grant = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        quiet = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (req_n && !flash_rd) quiet++;
        end
        check(quiet == 10, "R2", "quiet cycles without grant", quiet, 10);
        #1 grant = 1'b1;
        cnt = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!req_n) cnt++;
        end
        check(cnt > 0, "R2", "auto start on grant", cnt, 1);
        cnt = 0;
        while (!err_o && cnt < 50) begin @(negedge clk); cnt++; end
        check(err_o, "R8", "timeout after auto start", int'(err_o), 1);

        // R7: every page against every done position.
        for (int pg = 0; pg < (1 << PG_W); pg++)
            for (int k = 1; k <= IMG; k++)
                attempt(pg, (k % 3) + 1, k, 0, k, 1'b1, 1'b0, "R7");

        // R11: done persists without a restart.
        repeat (25) @(negedge clk);
        check(done_o && req_n, "R11", "done held", int'(done_o), 1);

        // R6: status loss after each word position.
        for (int k = 1; k <= IMG; k++)
            attempt(2, 2, 0, k, k, 1'b0, 1'b0, "R6");

        // R9: image length overrun on every page.
        for (int pg = 0; pg < (1 << PG_W); pg++)
            attempt(pg, 1, IMG + 1, 0, IMG, 1'b0, 1'b0, "R9");

        // R8: status never rises.
        attempt(1, 0, 0, 0, 0, 1'b0, 1'b1, "R8");

        // R10: a held-low request restarts only once; R11: release is ignored.
        tstatus = 1'b0; tdone = 1'b0;
        reconf_n = 1'b0;
        falls = 0; prev = req_n;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (prev && !req_n) falls++;
            prev = req_n;
        end
        check(falls == 1, "R10", "restarts from held level", falls, 1);
        #1 reconf_n = 1'b1;
        repeat (20) @(negedge clk);
        check(err_o && req_n, "R11", "error held after release", int'(err_o), 1);

        // R3: page change mid-stream does not move addresses.
        kick(1);
        do @(negedge clk); while (req_n);
        do @(negedge clk); while (!req_n);
        @(posedge clk); #1 tstatus = 1'b1;
        cnt = 0;
        while (cnt < 3) begin @(negedge clk); if (flash_rd) cnt++; end
        page_sel = 2'd3;
        @(negedge clk);
        check(flash_rd && int'(flash_addr) == 1 * (1 << WAW) + 3, "R3",
              "address after page change", int'(flash_addr), 1 * (1 << WAW) + 3);

        // R10: restart while streaming begins again at word 0 of the new page.
        @(posedge clk); #1 reconf_n = 1'b0;
        cnt = 0;
        while (req_n && cnt < 10) begin @(negedge clk); cnt++; end
        check(!req_n, "R10", "request after mid-stream restart", int'(req_n), 0);
        #1 reconf_n = 1'b1;
        do @(negedge clk); while (!flash_rd);
        check(int'(flash_addr) == 3 * (1 << WAW), "R10", "first address after restart",
              int'(flash_addr), 3 * (1 << WAW));

        // R2: grant loss stops reading in the same cycle and idles the block.
        @(posedge clk); #1 grant = 1'b0;
        #1 check(!flash_rd && flash_addr == '0, "R2", "read on grant loss",
                 int'(flash_rd), 0);
        quiet = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (req_n && !flash_rd && !done_o && !err_o) quiet++;
        end
        check(quiet == 12, "R2", "idle while grant low", quiet, 12);
        tstatus = 1'b0;
        #1 grant = 1'b1;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!req_n) cnt++;
        end
        check(cnt > 0, "R2", "new attempt on grant return", cnt, 1);
        cnt = 0;
        while (!err_o && cnt < 50) begin @(negedge clk); cnt++; end
        check(err_o && !done_o, "R12", "single end flag", int'(err_o), 1);

        summary();
        $finish;
    end
endmodule